// File: doc/BRIEF.md
# Multiplexed Bus Address/Data Demultiplexer

This block is the glue between a microcontroller running its external bus in expanded mode and an asynchronous byte-wide static memory. The controller drives the upper address byte on a dedicated port. The lower address byte and the data share one port. The lower byte is present only while the bus clock E is low, and a strobe marks it as valid. The block captures that byte and presents a full, stable address for the whole bus cycle. It derives active-low write and output strobes for the memory and decides which side drives the shared data lines.

All logic runs on a fast system clock, and the bus signals are sampled on its rising edge. The transfer direction is fixed at the rising edge of E. Memory strobes and data drivers are active only while E is high. Every transfer finishes inside one E period, with no wait states. The shared port is modelled as separate input, output and drive-enable signals. The memory data bus is modelled the same way. The pad tristate buffers belong outside this block.

Top module: `busdemux_top`

## Requirements
- R1: While `rstN` is low, `weN` and `oeN` are 1, `adDrive` and `memDrive` are 0, and `addr` is 0.
- R2: On a clock edge where `addrStrobe` is 1 and `eClk` is 0, `addr` loads `{addrHi, adIn}`, with the dedicated byte in bits 15:8. The new value is visible after that edge.
- R3: On every other edge `addr` keeps its value. This includes the data phase, idle periods between cycles, and an `addrStrobe` pulse while `eClk` is 1.
- R4: The transfer direction is taken from `rwN` on the first edge that samples `eClk` high: 1 selects read and 0 selects write. A change of `rwN` later in the same high phase has no effect.
- R5: During a read, `oeN` is 0 and `adDrive` is 1 for the whole high phase. From the second edge of that phase onward, `adOut` carries the byte the memory presents on `memDataIn`.
- R6: During a write, `weN` is 0 and `memDrive` is 1 for the whole high phase. `memDataOut` follows `adIn`, so the byte on `adIn` at the last edge before E falls is the one held when `weN` returns high.
- R7: `weN` and `oeN` are 0, and `adDrive` and `memDrive` are 1, only on edges following an edge that sampled `eClk` high. The first edge that samples `eClk` low releases all of them.
- R8: `weN` and `oeN` are never 0 at the same time, and `adDrive` and `memDrive` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| eClk | input | 1 | Bus clock E; low = address phase, high = data phase |
| addrStrobe | input | 1 | High while the low address byte is valid on `adIn` |
| rwN | input | 1 | Direction: 1 = read, 0 = write |
| addrHi | input | 8 | Dedicated upper address byte |
| adIn | input | 8 | Shared address/data port as seen by the block |
| adOut | output | 8 | Read data returned onto the shared port |
| adDrive | output | 1 | Enable for driving `adOut` onto the shared port |
| addr | output | 16 | Demultiplexed memory address |
| weN | output | 1 | Active-low memory write strobe |
| oeN | output | 1 | Active-low memory output strobe |
| memDataIn | input | 8 | Data presented by the memory |
| memDataOut | output | 8 | Write data toward the memory |
| memDrive | output | 1 | Enable for driving `memDataOut` onto the memory bus |

## Verification
The bench puts writes and reads back to back at addresses that differ in both bytes. A read of a location written just before it checks that the latched address and the write data both reached the memory model. A read of an untouched location checks the read path on its own. The shared port and the upper byte are scrambled after every address phase and during idle time, which separates a true latch from a pass-through. Two cycles flip `rwN` in mid-phase and pulse the address strobe while E is high, which shows whether direction and address are frozen at the right moments.

// File: rtl/busdemux_pkg.sv
package busdemux_pkg;

  // Which kind of transfer the data half of the E cycle is carrying
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } busPhase_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic latchAddr;  // capture {addrHi, adIn} as the cycle address
    logic loadWrite;  // capture adIn as write data
    logic loadRead;   // capture memory data for the bus
  } dpCtl_t;

endpackage

// File: rtl/busdemux_ctrl.sv
module busdemux_ctrl
  import busdemux_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   eClk,
  input  logic   addrStrobe,
  input  logic   rwN,
  output dpCtl_t dpCtl,
  output logic   weN,
  output logic   oeN,
  output logic   adDrive,
  output logic   memDrive
);

  busPhase_t phaseQ;
  busPhase_t phaseD;

  // The direction is fixed on entry to the high phase and then kept.
  always_comb begin
    phaseD = phaseQ;
    if (!eClk) begin
      phaseD = PH_IDLE;
    end else if (phaseQ == PH_IDLE) begin
      phaseD = rwN ? PH_READ : PH_WRITE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
    end else begin
      phaseQ <= phaseD;
    end
  end

  // The strobes decode from a registered state, so they are glitch free.
  assign oeN      = (phaseQ != PH_READ);
  assign weN      = (phaseQ != PH_WRITE);
  assign adDrive  = (phaseQ == PH_READ);
  assign memDrive = (phaseQ == PH_WRITE);

  assign dpCtl.latchAddr = addrStrobe && !eClk;
  assign dpCtl.loadWrite = (phaseD == PH_WRITE);
  assign dpCtl.loadRead  = (phaseQ == PH_READ);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !oeN) && !(adDrive && memDrive)); // R8

  AST_STROBE_IN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!weN || !oeN || adDrive || memDrive) |-> $past(eClk)); // R7

  AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$past(eClk) |-> (weN && oeN && !adDrive && !memDrive)); // R7

  AST_READ_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN && eClk) |=> (!oeN && weN)); // R4

  AST_WRITE_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && eClk) |=> (!weN && oeN)); // R4

endmodule

// File: rtl/busdemux_dp.sv
module busdemux_dp
  import busdemux_pkg::*;
#(
  parameter int HI_W = 8,
  parameter int AD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [HI_W-1:0]   addrHi,
  input  logic [AD_W-1:0]   adIn,
  input  logic [AD_W-1:0]   memDataIn,
  output logic [HI_W+AD_W-1:0] addr,
  output logic [AD_W-1:0]   memDataOut,
  output logic [AD_W-1:0]   adOut
);

  localparam int ADDR_W = HI_W + AD_W;

  logic [ADDR_W-1:0] addrQ;
  logic [AD_W-1:0]   wrQ;
  logic [AD_W-1:0]   rdQ;
  logic              postRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrQ     <= '0;
      rdQ     <= '0;
      postRst <= 1'b0;
    end else begin
      postRst <= 1'b1;
      if (dpCtl.latchAddr) addrQ <= {addrHi, adIn};
      if (dpCtl.loadWrite) wrQ   <= adIn;
      if (dpCtl.loadRead)  rdQ   <= memDataIn;
    end
  end

  assign addr       = addrQ;
  assign memDataOut = wrQ;
  assign adOut      = rdQ;

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (postRst && $past(dpCtl.latchAddr)) |-> (addr == $past({addrHi, adIn}))); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (postRst && !$past(dpCtl.latchAddr)) |-> $stable(addr)); // R3

endmodule

// File: rtl/busdemux_top.sv
module busdemux_top
  import busdemux_pkg::*;
#(
  parameter int HI_W = 8,
  parameter int AD_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 eClk,
  input  logic                 addrStrobe,
  input  logic                 rwN,
  input  logic [HI_W-1:0]      addrHi,
  input  logic [AD_W-1:0]      adIn,
  output logic [AD_W-1:0]      adOut,
  output logic                 adDrive,
  output logic [HI_W+AD_W-1:0] addr,
  output logic                 weN,
  output logic                 oeN,
  input  logic [AD_W-1:0]      memDataIn,
  output logic [AD_W-1:0]      memDataOut,
  output logic                 memDrive
);

  dpCtl_t dpCtl;

  busdemux_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .eClk      (eClk),
    .addrStrobe(addrStrobe),
    .rwN       (rwN),
    .dpCtl     (dpCtl),
    .weN       (weN),
    .oeN       (oeN),
    .adDrive   (adDrive),
    .memDrive  (memDrive)
  );

  busdemux_dp #(.HI_W(HI_W), .AD_W(AD_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .addrHi    (addrHi),
    .adIn      (adIn),
    .memDataIn (memDataIn),
    .addr      (addr),
    .memDataOut(memDataOut),
    .adOut     (adOut)
  );

endmodule

// File: tb/busdemux_top_test.sv
`timescale 1ns/1ps
module busdemux_top_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic        eClk = 1'b0, addrStrobe = 1'b0, rwN = 1'b1;
  logic [7:0]  addrHi = '0, adIn = '0;
  logic [7:0]  adOut, memDataIn, memDataOut;
  logic        adDrive, weN, oeN, memDrive;
  logic [15:0] addr;

  busdemux_top uut (
    .clk(clk), .rstN(rstN), .eClk(eClk), .addrStrobe(addrStrobe), .rwN(rwN),
    .addrHi(addrHi), .adIn(adIn), .adOut(adOut), .adDrive(adDrive), .addr(addr),
    .weN(weN), .oeN(oeN), .memDataIn(memDataIn), .memDataOut(memDataOut),
    .memDrive(memDrive)
  );

  // Behavioural memory, indexed by the low address byte
  logic [7:0] memArr [256];
  logic [7:0] sbMem  [256];
  assign memDataIn = oeN ? 8'h00 : memArr[addr[7:0]];
  always @(posedge clk) if (!weN && memDrive) memArr[addr[7:0]] <= memDataOut;

  typedef struct { bit isWr; logic [15:0] a; logic [7:0] d; } item_t;
  item_t expQ[$];

  int nRun = 0, nFail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sampleTick();
    @(posedge clk); #5;
  endtask

  // Driver: one full E cycle; pushes the expected transfer to the scoreboard
  task automatic busCycle(bit wr, logic [15:0] a, logic [7:0] d, bit twist);
    item_t it;
    @(negedge clk);
    eClk = 1'b0; addrStrobe = 1'b1; addrHi = a[15:8]; adIn = a[7:0]; rwN = !wr;
    @(negedge clk); @(negedge clk);
    addrStrobe = 1'b0; adIn = ~a[7:0]; addrHi = ~a[15:8];
    sampleTick();
    chk(addr == a, "R3", "address held after strobe", addr, a);
    @(negedge clk);
    it.isWr = wr; it.a = a;
    if (wr) begin it.d = d; sbMem[a[7:0]] = d; end
    else it.d = sbMem[a[7:0]];
    expQ.push_back(it);
    eClk = 1'b1; adIn = wr ? ~d : 8'h00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (wr) adIn = d;
      if (twist && k == 0) begin rwN = !rwN; addrStrobe = 1'b1; adIn = wr ? d : 8'hE7; end
      if (twist && k == 1) addrStrobe = 1'b0;
    end
    @(negedge clk);
    eClk = 1'b0; adIn = 8'h00; rwN = 1'b1;
    sampleTick();
    chk(addr == a, "R3", "address held after E fall", addr, a);
  endtask

  // Monitor: pops the expected transfer when strobes appear, compares at release
  initial begin
    item_t cur;
    bit active = 0;
    logic [7:0] lastData = '0;
    cur.isWr = 0; cur.a = '0; cur.d = '0;
    forever begin
      sampleTick();
      if (rstN) begin
        chk(!(!weN && !oeN) && !(adDrive && memDrive), "R8", "strobe exclusivity",
            {weN, oeN, adDrive, memDrive}, 4'b1100);
        if (!eClk)
          chk(weN && oeN && !adDrive && !memDrive, "R7", "inactive while E low",
              {weN, oeN, adDrive, memDrive}, 4'b1100);
        if (!weN || !oeN) begin
          if (!active) begin
            active = 1;
            if (expQ.size() == 0) begin
              chk(0, "R7", "strobe with no transfer pending", {weN, oeN}, 2'b11);
            end else begin
              cur = expQ.pop_front();
              chk(addr == cur.a, "R2", "latched address at strobe", addr, cur.a);
            end
          end
          chk(weN == !cur.isWr && oeN == cur.isWr, "R4", "direction kept",
              {weN, oeN}, {!cur.isWr, cur.isWr});
          if (cur.isWr)
            chk(memDrive && !adDrive, "R6", "memory side driven", {memDrive, adDrive}, 2'b10);
          else
            chk(adDrive && !memDrive, "R5", "bus side driven", {adDrive, memDrive}, 2'b10);
          lastData = cur.isWr ? memDataOut : adOut;
        end else if (active) begin
          active = 0;
          if (cur.isWr)
            chk(lastData == cur.d, "R6", "write data at strobe end", lastData, cur.d);
          else
            chk(lastData == cur.d, "R5", "read data at E fall", lastData, cur.d);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      memArr[i] = 8'(i) ^ 8'h5A;
      sbMem[i]  = 8'(i) ^ 8'h5A;
    end
    // R1: reset state, even with activity on the inputs
    addrStrobe = 1'b1; adIn = 8'h3F; addrHi = 8'hC1;
    repeat (3) sampleTick();
    chk(weN == 1'b1, "R1", "weN in reset", weN, 1);
    chk(oeN == 1'b1, "R1", "oeN in reset", oeN, 1);
    chk(adDrive == 1'b0, "R1", "adDrive in reset", adDrive, 0);
    chk(memDrive == 1'b0, "R1", "memDrive in reset", memDrive, 0);
    chk(addr == 16'h0000, "R1", "addr in reset", addr, 0);
    @(negedge clk);
    addrStrobe = 1'b0; adIn = 8'h00; addrHi = 8'h00;
    rstN = 1'b1;

    busCycle(1, 16'h1234, 8'hA5, 0);
    busCycle(1, 16'hBE40, 8'h3C, 0);
    busCycle(0, 16'h1234, 8'h00, 0);
    busCycle(0, 16'h0077, 8'h00, 0);
    busCycle(0, 16'hBE40, 8'h00, 1); // R4: rwN flips mid-phase, R3: strobe while E high
    busCycle(1, 16'h2211, 8'h99, 1); // R4: write stays write
    busCycle(0, 16'h2211, 8'h00, 0);

    // R3: idle time with traffic on the shared port
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      adIn = 8'(k * 37); addrHi = 8'(k * 11);
    end
    sampleTick();
    chk(addr == 16'h2211, "R3", "address held while idle", addr, 16'h2211);
    chk(expQ.size() == 0, "R7", "every transfer seen", expQ.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule